// File: doc/BRIEF.md
# Converter Mode Control Register Bank

This block holds the mode controls of an audio converter in a two-register file that a simple host port reaches by address and byte data. Each register exists twice: a shadow copy that the host writes and reads back, and an active copy that drives the control outputs. A freeze bit in the main mode register keeps the active copy fixed while several writes collect in the shadow copy. Clearing the bit moves every pending value to the outputs at one clock edge.

The outputs are a control-port enable, a power-down request, a select for an internal divide-by-2 of the master clock, a filter roll-off select and one mute output per channel. A tie bit can make every mute output the AND of all channel mute requests. A start-up watchdog raises a sticky flag if the host does not write the main mode register within a set number of cycles after reset is released.

Top module: `mode_ctl_bank`

## Requirements
- R1: After reset, ctl_port_en_o is 0, pwr_down_o is 1, mclk_div2_o is 0, filt_slow_o is 0, timeout_o is 0, and reads return 10h at address 05h and 00h at address 06h.
- R2: The mode register is at address 05h. Bit 5 is control-port enable, bit 4 is power-down, bit 3 is mute tie, bit 2 is freeze and bit 1 is master-clock divide-by-2. When a write leaves freeze at 0, its fields reach the outputs at the same clock edge that stores it.
- R3: Power-down never clears the registers. Contents stay unchanged while no write arrives, and writes are still accepted while power-down is 1.
- R4: While the stored freeze bit is 1, writes change the read-back values but none of the register-driven outputs change.
- R5: A write to 05h with bit 2 = 0 takes effect at once, and at that edge it moves all shadow values of both registers to the outputs. A write that sets bit 2 to 1 holds the other fields of that same write.
- R6: The filter register is at address 06h. Bit 4 drives filt_slow_o (0 selects fast roll-off, 1 selects slow roll-off).
- R7: With the active tie bit at 0, mute_o[i] follows mute_req_i[i]. With it at 1, every mute_o bit equals the AND of all mute_req_i bits. The path is combinational.
- R8: Reserved bits read as 0 and ignore writes. At 05h only the mask 3Eh is stored, and at 06h only the mask 10h.
- R9: Writes to any address other than 05h and 06h change nothing, and reads of such addresses return 00h.
- R10: If no write to 05h occurs at clock edges 1 to TIMEOUT_CYC after reset release, timeout_o rises at edge TIMEOUT_CYC and stays 1 until reset. A write to 05h at any of those edges keeps timeout_o at 0.
- R11: rd_data_o returns the shadow (last-written) value of the register at addr_i combinationally, with no wait cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the host port |
| addr_i | input | ADDR_W | Register address |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data (shadow value) |
| mute_req_i | input | NUM_CH | Per-channel mute requests |
| mute_o | output | NUM_CH | Per-channel mute outputs |
| ctl_port_en_o | output | 1 | Control-port mode enable |
| pwr_down_o | output | 1 | Power-down request |
| mclk_div2_o | output | 1 | Master-clock divide-by-2 select |
| filt_slow_o | output | 1 | Slow roll-off filter select |
| timeout_o | output | 1 | Start-up write window expired |

## Verification
The bench builds the block with TIMEOUT_CYC = 20 instead of the default window of more than a hundred thousand cycles. This lets it check both edges of the timeout boundary exactly, and also the case where a write prevents the flag, within a short run. It keeps NUM_CH = 2 and ADDR_W = 8. With that address width, random addresses reach many unimplemented locations next to the two real registers.

// File: rtl/mode_ctl_pkg.sv
package mode_ctl_pkg;
  localparam logic [7:0] MODE_ADDR = 8'h05;
  localparam logic [7:0] FILT_ADDR = 8'h06;

  localparam logic [7:0] MODE_MASK = 8'h3E;
  localparam logic [7:0] FILT_MASK = 8'h10;

  localparam logic [7:0] MODE_RST = 8'h10;
  localparam logic [7:0] FILT_RST = 8'h00;

  localparam int CPEN_B = 5;
  localparam int PDN_B  = 4;
  localparam int TIE_B  = 3;
  localparam int FRZ_B  = 2;
  localparam int DIV_B  = 1;
  localparam int SLOW_B = 4;
endpackage

// File: rtl/mode_ctl_regs.sv
module mode_ctl_regs
  import mode_ctl_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        rd_data_o,
  output logic              mode_wr_o,
  output logic              cpen_o,
  output logic              pdn_o,
  output logic              tie_o,
  output logic              div_o,
  output logic              slow_o
);
  localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_ADDR);
  localparam logic [ADDR_W-1:0] FILT_A = ADDR_W'(FILT_ADDR);

  logic [7:0] shd_mode_q, shd_filt_q, shd_mode_d, shd_filt_d;
  logic [7:0] act_mode_q, act_filt_q;
  logic       sel_mode, sel_filt;

  assign sel_mode  = (addr_i == MODE_A);
  assign sel_filt  = (addr_i == FILT_A);
  assign mode_wr_o = wr_en_i && sel_mode;

  always_comb begin
    shd_mode_d = shd_mode_q;
    shd_filt_d = shd_filt_q;
    if (wr_en_i && sel_mode) shd_mode_d = wr_data_i & MODE_MASK;
    if (wr_en_i && sel_filt) shd_filt_d = wr_data_i & FILT_MASK;
  end

  // freeze acts on the incoming value so a release write commits in its own cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_mode_q <= MODE_RST;
      shd_filt_q <= FILT_RST;
      act_mode_q <= MODE_RST;
      act_filt_q <= FILT_RST;
    end else begin
      shd_mode_q <= shd_mode_d;
      shd_filt_q <= shd_filt_d;
      if (!shd_mode_d[FRZ_B]) begin
        act_mode_q <= shd_mode_d;
        act_filt_q <= shd_filt_d;
      end
    end
  end

  always_comb begin
    rd_data_o = 8'h00;
    if (sel_mode)      rd_data_o = shd_mode_q;
    else if (sel_filt) rd_data_o = shd_filt_q;
  end

  assign cpen_o = act_mode_q[CPEN_B];
  assign pdn_o  = act_mode_q[PDN_B];
  assign tie_o  = act_mode_q[TIE_B];
  assign div_o  = act_mode_q[DIV_B];
  assign slow_o = act_filt_q[SLOW_B];

  AST_FROZEN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shd_mode_q[FRZ_B] && !(mode_wr_o && !wr_data_i[FRZ_B])) |=> $stable({act_mode_q, act_filt_q})); // R4
  AST_RELEASE_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_wr_o && !wr_data_i[FRZ_B]) |=> (act_mode_q == shd_mode_q && act_filt_q == shd_filt_q)); // R5
  AST_PDN_RETAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && pdn_o) |=> $stable({shd_mode_q, shd_filt_q})); // R3
  AST_RSVD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rd_data_o & ~(sel_mode ? MODE_MASK : FILT_MASK)) == 8'h00)); // R8
  AST_UNMAPPED_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_mode && !sel_filt) |-> rd_data_o == 8'h00); // R9
endmodule

// File: rtl/mode_ctl_mute.sv
module mode_ctl_mute #(
  parameter int NUM_CH = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tie_i,
  input  logic [NUM_CH-1:0] req_i,
  output logic [NUM_CH-1:0] mute_o
);
  logic all_req;
  assign all_req = &req_i;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    assign mute_o[ch] = tie_i ? all_req : req_i[ch];
  end

  AST_TIE_UNIFORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tie_i |-> (mute_o == '0 || mute_o == '1)); // R7
  AST_TIE_NO_EXTRA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tie_i |-> ((mute_o & ~req_i) == '0)); // R7
endmodule

// File: rtl/mode_ctl_init_wdog.sv
module mode_ctl_init_wdog #(
  parameter int TIMEOUT_CYC = 122880
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic timeout_o
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             seen_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      flag_q <= 1'b0;
    end else if (!seen_q && !flag_q) begin
      if (kick_i)                                seen_q <= 1'b1;
      else if (cnt_q == CNT_W'(TIMEOUT_CYC - 1)) flag_q <= 1'b1;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign timeout_o = flag_q;

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q |=> flag_q); // R10
  AST_KICK_BLOCKS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |=> !flag_q); // R10
endmodule

// File: rtl/mode_ctl_bank.sv
module mode_ctl_bank #(
  parameter int ADDR_W      = 8,
  parameter int NUM_CH      = 2,
  parameter int TIMEOUT_CYC = 122880
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [7:0]        rd_data_o,
  input  logic [NUM_CH-1:0] mute_req_i,
  output logic [NUM_CH-1:0] mute_o,
  output logic              ctl_port_en_o,
  output logic              pwr_down_o,
  output logic              mclk_div2_o,
  output logic              filt_slow_o,
  output logic              timeout_o
);
  logic mode_wr, tie;

  mode_ctl_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .addr_i    (addr_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .mode_wr_o (mode_wr),
    .cpen_o    (ctl_port_en_o),
    .pdn_o     (pwr_down_o),
    .tie_o     (tie),
    .div_o     (mclk_div2_o),
    .slow_o    (filt_slow_o)
  );

  mode_ctl_mute #(.NUM_CH(NUM_CH)) u_mute (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tie_i  (tie),
    .req_i  (mute_req_i),
    .mute_o (mute_o)
  );

  mode_ctl_init_wdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .kick_i    (mode_wr),
    .timeout_o (timeout_o)
  );

  AST_UNFROZEN_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == ADDR_W'(8'h05) && !wr_data_i[2]) |=>
      (ctl_port_en_o == $past(wr_data_i[5]) && pwr_down_o == $past(wr_data_i[4])
       && mclk_div2_o == $past(wr_data_i[1]))); // R2
endmodule

// File: tb/mode_ctl_bank_bench.sv
module mode_ctl_bank_bench;
  localparam int ADDR_W = 8;
  localparam int NUM_CH = 2;
  localparam int TMO    = 20;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        wdata = '0;
  logic [7:0]        rdata;
  logic [NUM_CH-1:0] mreq = '0;
  logic [NUM_CH-1:0] mute;
  logic              cpen, pdn, div2, slow, tmo;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] shd5, shd6, act5, act6;

  always #10 clk = ~clk;

  mode_ctl_bank #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .TIMEOUT_CYC(TMO)) u_mode_ctl_bank (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr), .wr_data_i(wdata),
    .rd_data_o(rdata), .mute_req_i(mreq), .mute_o(mute), .ctl_port_en_o(cpen),
    .pwr_down_o(pdn), .mclk_div2_o(div2), .filt_slow_o(slow), .timeout_o(tmo)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [NUM_CH-1:0] exp_mute(input logic tie, input logic [NUM_CH-1:0] r);
    return tie ? {NUM_CH{&r}} : r;
  endfunction

  task automatic finish_sim();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; wr_en = 1'b0;
    shd5 = 8'h10; shd6 = 8'h00; act5 = 8'h10; act6 = 8'h00;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // one bus cycle: drive at negedge, model at posedge, back to negedge
  task automatic bus(input logic we, input logic [7:0] a, input logic [7:0] d);
    wr_en = we; addr = a; wdata = d;
    @(posedge clk);
    if (we && a == 8'h05) shd5 = d & 8'h3E;
    if (we && a == 8'h06) shd6 = d & 8'h10;
    if (!shd5[2]) begin act5 = shd5; act6 = shd6; end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R2 cpen"}, {7'd0, cpen}, {7'd0, act5[5]});
    chk({tag, " R2 pdn"},  {7'd0, pdn},  {7'd0, act5[4]});
    chk({tag, " R2 div"},  {7'd0, div2}, {7'd0, act5[1]});
    chk({tag, " R6 slow"}, {7'd0, slow}, {7'd0, act6[4]});
    addr = 8'h05; #1;
    chk({tag, " R11 rd05"}, rdata, shd5);
    addr = 8'h06; #1;
    chk({tag, " R11 rd06"}, rdata, shd6);
    mreq = NUM_CH'($urandom); #1;
    chk({tag, " R7 mute"}, 8'(mute), 8'(exp_mute(act5[3], mreq)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_sim();
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    do_reset();
    // R1 reset state
    #1;
    chk("R1 cpen", {7'd0, cpen}, 8'h00);
    chk("R1 pdn",  {7'd0, pdn},  8'h01);
    chk("R1 div",  {7'd0, div2}, 8'h00);
    chk("R1 slow", {7'd0, slow}, 8'h00);
    chk("R1 tmo",  {7'd0, tmo},  8'h00);
    addr = 8'h05; #1; chk("R1 rd05", rdata, 8'h10);
    addr = 8'h06; #1; chk("R1 rd06", rdata, 8'h00);

    // R10 timeout boundary: no write at edges 1..TMO
    for (int i = 0; i < TMO - 1; i++) bus(1'b0, 8'h00, 8'h00);
    chk("R10 before edge", {7'd0, tmo}, 8'h00);
    bus(1'b0, 8'h00, 8'h00);
    chk("R10 at edge", {7'd0, tmo}, 8'h01);
    bus(1'b1, 8'h05, 8'h30);
    chk("R10 sticky", {7'd0, tmo}, 8'h01);

    // R10 write at the last edge of the window prevents the flag
    do_reset();
    for (int i = 0; i < TMO - 1; i++) bus(1'b0, 8'h00, 8'h00);
    bus(1'b1, 8'h05, 8'h30);
    repeat (2 * TMO) bus(1'b0, 8'h00, 8'h00);
    chk("R10 kicked", {7'd0, tmo}, 8'h00);
    check_all("R2 clean power-up");

    // R8 reserved bits
    bus(1'b1, 8'h05, 8'hC1);
    check_all("R8 rsvd05");
    bus(1'b1, 8'h06, 8'hEF);
    check_all("R8 rsvd06");

    // R4/R5 freeze then release
    bus(1'b1, 8'h05, 8'h14);
    check_all("R4 set frz");
    bus(1'b1, 8'h06, 8'h10);
    chk("R4 slow held", {7'd0, slow}, 8'h00);
    check_all("R4 frozen");
    bus(1'b1, 8'h05, 8'h3E);
    chk("R4 cpen held", {7'd0, cpen}, 8'h00);
    check_all("R4 frozen2");
    bus(1'b1, 8'h05, 8'h2A);
    chk("R5 slow commit", {7'd0, slow}, 8'h01);
    chk("R5 div commit",  {7'd0, div2}, 8'h01);
    check_all("R5 release");

    // R9 unmapped addresses
    bus(1'b1, 8'h07, 8'hFF);
    bus(1'b1, 8'h04, 8'hFF);
    addr = 8'h07; #1; chk("R9 rd07", rdata, 8'h00);
    check_all("R9 no effect");

    // R3 power-down keeps contents and accepts writes
    bus(1'b1, 8'h05, 8'h10);
    repeat (5) bus(1'b0, 8'h00, 8'h00);
    check_all("R3 retain");
    bus(1'b1, 8'h06, 8'h10);
    check_all("R3 write in pdn");

    // R7 tie directed
    bus(1'b1, 8'h05, 8'h08);
    mreq = 2'b01; #1; chk("R7 tie one", 8'(mute), 8'h00);
    mreq = 2'b11; #1; chk("R7 tie both", 8'(mute), 8'h03);
    bus(1'b1, 8'h05, 8'h00);
    mreq = 2'b10; #1; chk("R7 untied", 8'(mute), 8'h02);

    // random traffic, biased toward the two registers
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a;
      int sel;
      sel = $urandom_range(0, 3);
      a = (sel == 0) ? 8'h05 : (sel == 1) ? 8'h06 : (sel == 2) ? 8'(($urandom & 1) ? 8'h05 : 8'h06)
                                                      : 8'($urandom);
      bus(1'($urandom), a, 8'($urandom));
      check_all("R4 R5 random");
    end

    finish_sim();
  end
endmodule